// File: doc/BRIEF.md
# System-Call Vector Dispatch Sequencer

This block is the execution slice that carries out a system-call trap on a 16-bit processor, plus the return that goes with it. When instruction decode presents a trap with its 8-bit vector and the program counter that was already advanced past the trap, the sequencer forms a lookup address in a 256-word table in the lowest page of memory. It issues one read there and waits as long as memory takes to answer. In one commit cycle it then writes the saved link into general register 7 and loads the word it read as the new program counter.

A return takes the value of register 7, offered by the register file on a read port, and loads it as the program counter one cycle after it is accepted. Both operations end with a one-cycle completion strobe. While a sequence is in flight, further requests are dropped, so decode must hold off until the block is idle again. The memory side is a single-cycle request followed, some cycles later, by a one-cycle response strobe that carries the data.

Top module: `trap_dispatch_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `mem_req`, `rf_we`, `pc_we` and `done` are all low.
- R2: A trap request seen while idle causes, in the next cycle, a one-cycle `mem_req` with `mem_addr` equal to the vector zero-extended to 16 bits (table base 0x0000, so the address lies in 0x0000..0x00FF).
- R3: After issuing the read the block waits, without limit, for `mem_rdy`. No register or program-counter write happens before it. A `mem_rdy` pulse while idle or in the issue cycle is ignored.
- R4: In the cycle after `mem_rdy` is seen while waiting, `rf_we` is high with `rf_waddr` = 7 and `rf_wdata` equal to `pc_in` as captured when the trap was accepted. `pc_we` is high in the same cycle with `pc_next` equal to the `mem_rdata` sampled with `mem_rdy`.
- R5: A return request seen while idle with no trap request causes, in the next cycle, `pc_we` with `pc_next` equal to `r7_val` as sampled at acceptance. There is no register write and no memory request.
- R6: When a trap request and a return request arrive together while idle, the trap is taken and the return is dropped.
- R7: While busy, trap and return requests are ignored: the table address, the link and the target of the running sequence stay unchanged, and no extra memory request is issued.
- R8: `done` is high for exactly one cycle, the cycle in which `pc_we` is high. `busy` is high from the cycle after acceptance through that cycle and low in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| trap_req | input | 1 | Trap request from decode |
| trap_vec | input | 8 | Trap vector |
| pc_in | input | 16 | Incremented program counter (link value) |
| ret_req | input | 1 | Return request from decode |
| r7_val | input | 16 | Current contents of register 7 |
| mem_req | output | 1 | One-cycle table read request |
| mem_addr | output | 16 | Table read address |
| mem_rdy | input | 1 | Read response strobe |
| mem_rdata | input | 16 | Read data, valid with `mem_rdy` |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 3 | Register-file write index |
| rf_wdata | output | 16 | Register-file write data |
| pc_we | output | 1 | Program-counter load enable |
| pc_next | output | 16 | New program counter |
| busy | output | 1 | Sequence in flight |
| done | output | 1 | Completion strobe |

## Verification
The assertions watch every cycle for the ordering rules: the request pulse and its address after an accepted trap, no write before a response, commits that always follow a response and target register 7, return loads, the trap-first rule, a frozen table address while busy, and the single-cycle completion strobe. Only the bench's scenarios can show that the link and target values end up where they should across a whole sequence. That covers a link captured many cycles before the commit, data taken from the right response when stray strobes and noisy requests surround it, and the extreme vectors 0x00 and 0xFF mapping to the ends of the table.

// File: rtl/trapseq_pkg.sv
package trapseq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ISSUE  = 3'd1,
    ST_WAIT   = 3'd2,
    ST_COMMIT = 3'd3,
    ST_RETURN = 3'd4
  } seq_state_t;
endpackage

// File: rtl/trap_seq_rst_sync.sv
module trap_seq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_core_n = sync_q[STAGES-1];
endmodule

// File: rtl/trap_seq_fsm.sv
module trap_seq_fsm
  import trapseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trap_req,
  input  logic       ret_req,
  input  logic       mem_rdy,
  output seq_state_t state,
  output logic       accept_trap,
  output logic       accept_ret,
  output logic       take_data
);
  seq_state_t state_nx;

  // Requests are only looked at while idle; trap wins over return.
  assign accept_trap = (state == ST_IDLE) && trap_req;
  assign accept_ret  = (state == ST_IDLE) && !trap_req && ret_req;
  // The response strobe only counts once the read has been issued.
  assign take_data   = (state == ST_WAIT) && mem_rdy;

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE: begin
        if (accept_trap)     state_nx = ST_ISSUE;
        else if (accept_ret) state_nx = ST_RETURN;
      end
      ST_ISSUE:  state_nx = ST_WAIT;
      ST_WAIT:   if (take_data) state_nx = ST_COMMIT;
      ST_COMMIT: state_nx = ST_IDLE;
      ST_RETURN: state_nx = ST_IDLE;
      default:   state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end
endmodule

// File: rtl/trap_seq_capture.sv
module trap_seq_capture #(
  parameter int XLEN  = 16,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             accept_trap,
  input  logic             accept_ret,
  input  logic             take_data,
  input  logic [VEC_W-1:0] trap_vec,
  input  logic [XLEN-1:0]  pc_in,
  input  logic [XLEN-1:0]  r7_val,
  input  logic [XLEN-1:0]  mem_rdata,
  output logic [VEC_W-1:0] vec_q,
  output logic [XLEN-1:0]  link_q,
  output logic [XLEN-1:0]  target_q
);
  logic             vec_en, link_en, target_en;
  logic [XLEN-1:0]  target_d;

  assign vec_en    = accept_trap;
  assign link_en   = accept_trap;
  assign target_en = take_data || accept_ret;
  assign target_d  = take_data ? mem_rdata : r7_val;

  // Datapath registers: loaded only through their enables, no reset needed.
  always_ff @(posedge clk) begin
    if (vec_en)    vec_q    <= trap_vec;
    if (link_en)   link_q   <= pc_in;
    if (target_en) target_q <= target_d;
  end
endmodule

// File: rtl/trap_seq_drive.sv
module trap_seq_drive
  import trapseq_pkg::*;
#(
  parameter int              XLEN       = 16,
  parameter int              VEC_W      = 8,
  parameter int              RF_AW      = 3,
  parameter int              LINK_IDX   = 7,
  parameter logic [XLEN-1:0] TABLE_BASE = '0
) (
  input  seq_state_t       state,
  input  logic [VEC_W-1:0] vec_q,
  input  logic [XLEN-1:0]  link_q,
  input  logic [XLEN-1:0]  target_q,
  output logic             mem_req,
  output logic [XLEN-1:0]  mem_addr,
  output logic             rf_we,
  output logic [RF_AW-1:0] rf_waddr,
  output logic [XLEN-1:0]  rf_wdata,
  output logic             pc_we,
  output logic [XLEN-1:0]  pc_next,
  output logic             busy,
  output logic             done
);
  localparam int PAD = XLEN - VEC_W;
  localparam logic [RF_AW-1:0] LINK_ADDR = RF_AW'(LINK_IDX);

  logic [XLEN-1:0] vec_ext;

  generate
    if (PAD > 0) begin : g_pad
      assign vec_ext = {{PAD{1'b0}}, vec_q};
    end else begin : g_nopad
      assign vec_ext = vec_q[XLEN-1:0];
    end
  endgenerate

  always_comb begin
    mem_req  = (state == ST_ISSUE);
    mem_addr = TABLE_BASE + vec_ext;
    rf_we    = (state == ST_COMMIT);
    rf_waddr = LINK_ADDR;
    rf_wdata = link_q;
    pc_we    = (state == ST_COMMIT) || (state == ST_RETURN);
    pc_next  = target_q;
    done     = pc_we;
    busy     = (state != ST_IDLE);
  end
endmodule

// File: rtl/trap_dispatch_seq.sv
module trap_dispatch_seq
  import trapseq_pkg::*;
#(
  parameter int              XLEN       = 16,
  parameter int              VEC_W      = 8,
  parameter int              RF_AW      = 3,
  parameter int              LINK_IDX   = 7,
  parameter logic [XLEN-1:0] TABLE_BASE = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trap_req,
  input  logic [VEC_W-1:0] trap_vec,
  input  logic [XLEN-1:0]  pc_in,
  input  logic             ret_req,
  input  logic [XLEN-1:0]  r7_val,
  output logic             mem_req,
  output logic [XLEN-1:0]  mem_addr,
  input  logic             mem_rdy,
  input  logic [XLEN-1:0]  mem_rdata,
  output logic             rf_we,
  output logic [RF_AW-1:0] rf_waddr,
  output logic [XLEN-1:0]  rf_wdata,
  output logic             pc_we,
  output logic [XLEN-1:0]  pc_next,
  output logic             busy,
  output logic             done
);
  logic             rst_core_n;
  seq_state_t       state;
  logic             accept_trap, accept_ret, take_data;
  logic [VEC_W-1:0] vec_q;
  logic [XLEN-1:0]  link_q, target_q;

  trap_seq_rst_sync #(.STAGES(2)) i_rst (
    .clk(clk), .rst_n(rst_n), .rst_core_n(rst_core_n)
  );

  trap_seq_fsm i_fsm (
    .clk(clk), .rst_n(rst_core_n), .trap_req(trap_req), .ret_req(ret_req),
    .mem_rdy(mem_rdy), .state(state), .accept_trap(accept_trap),
    .accept_ret(accept_ret), .take_data(take_data)
  );

  trap_seq_capture #(.XLEN(XLEN), .VEC_W(VEC_W)) i_cap (
    .clk(clk), .accept_trap(accept_trap), .accept_ret(accept_ret),
    .take_data(take_data), .trap_vec(trap_vec), .pc_in(pc_in),
    .r7_val(r7_val), .mem_rdata(mem_rdata), .vec_q(vec_q),
    .link_q(link_q), .target_q(target_q)
  );

  trap_seq_drive #(
    .XLEN(XLEN), .VEC_W(VEC_W), .RF_AW(RF_AW),
    .LINK_IDX(LINK_IDX), .TABLE_BASE(TABLE_BASE)
  ) i_drv (
    .state(state), .vec_q(vec_q), .link_q(link_q), .target_q(target_q),
    .mem_req(mem_req), .mem_addr(mem_addr), .rf_we(rf_we),
    .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .pc_we(pc_we),
    .pc_next(pc_next), .busy(busy), .done(done)
  );
endmodule

// File: rtl/trap_dispatch_seq_chk.sv
module trap_dispatch_seq_chk #(
  parameter int              XLEN       = 16,
  parameter int              VEC_W      = 8,
  parameter int              RF_AW      = 3,
  parameter int              LINK_IDX   = 7,
  parameter logic [XLEN-1:0] TABLE_BASE = '0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trap_req,
  input logic [VEC_W-1:0] trap_vec,
  input logic             ret_req,
  input logic [XLEN-1:0]  r7_val,
  input logic             mem_req,
  input logic [XLEN-1:0]  mem_addr,
  input logic             mem_rdy,
  input logic             rf_we,
  input logic [RF_AW-1:0] rf_waddr,
  input logic             pc_we,
  input logic [XLEN-1:0]  pc_next,
  input logic             busy,
  input logic             done
);
  localparam int PAD = XLEN - VEC_W;

  // R2
  trap_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && trap_req) |=> (mem_req &&
      mem_addr == TABLE_BASE + {{PAD{1'b0}}, $past(trap_vec)}));

  // R2
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  // R3
  no_early_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> (!rf_we && !pc_we));

  // R4
  commit_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> $past(mem_rdy));

  // R4
  link_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (pc_we && rf_waddr == RF_AW'(LINK_IDX)));

  // R5
  ret_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !trap_req && ret_req) |=>
      (pc_we && !rf_we && !mem_req && pc_next == $past(r7_val)));

  // R6
  trap_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && trap_req && ret_req) |=> (mem_req && !pc_we));

  // R7
  busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mem_addr));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  // R8
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
endmodule

bind trap_dispatch_seq trap_dispatch_seq_chk #(
  .XLEN(XLEN), .VEC_W(VEC_W), .RF_AW(RF_AW),
  .LINK_IDX(LINK_IDX), .TABLE_BASE(TABLE_BASE)
) i_chk (
  .clk(clk), .rst_n(rst_core_n), .trap_req(trap_req), .trap_vec(trap_vec),
  .ret_req(ret_req), .r7_val(r7_val), .mem_req(mem_req),
  .mem_addr(mem_addr), .mem_rdy(mem_rdy), .rf_we(rf_we),
  .rf_waddr(rf_waddr), .pc_we(pc_we), .pc_next(pc_next),
  .busy(busy), .done(done)
);

// File: tb/test_trap_dispatch_seq.sv
`timescale 1ns/1ps
module test_trap_dispatch_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        trap_req, ret_req, mem_rdy;
  logic [7:0]  trap_vec;
  logic [15:0] pc_in, r7_val, mem_rdata;
  logic        mem_req, rf_we, pc_we, busy, done;
  logic [15:0] mem_addr, rf_wdata, pc_next;
  logic [2:0]  rf_waddr;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  trap_dispatch_seq i_trap_dispatch_seq (
    .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_vec(trap_vec),
    .pc_in(pc_in), .ret_req(ret_req), .r7_val(r7_val), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rdy(mem_rdy), .mem_rdata(mem_rdata),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .pc_we(pc_we), .pc_next(pc_next), .busy(busy), .done(done)
  );

  function automatic logic [15:0] exp_table_addr(input logic [7:0] v);
    return {8'h00, v};
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_checks(input string tag);
    chk(!busy, tag, 16'(busy), 16'h0);
    chk(!mem_req && !rf_we && !pc_we && !done, tag,
        {12'h0, mem_req, rf_we, pc_we, done}, 16'h0);
  endtask

  task automatic do_trap(input logic [7:0] v, input logic [15:0] pc,
                         input logic [15:0] tgt, input int lat,
                         input bit noise, input bit early_rdy, input bit both);
    @(negedge clk);
    trap_req = 1'b1; trap_vec = v; pc_in = pc;
    ret_req = both; r7_val = 16'($urandom());
    @(negedge clk);
    trap_req = 1'b0; ret_req = 1'b0;
    chk(mem_req, "R2 req", 16'(mem_req), 16'h1);
    chk(mem_addr == exp_table_addr(v), "R2 addr", mem_addr, exp_table_addr(v));
    chk(busy, "R8 busy", 16'(busy), 16'h1);
    if (both) chk(mem_req && !pc_we, "R6 trap first", 16'(pc_we), 16'h0);
    if (early_rdy) begin
      mem_rdy = 1'b1; mem_rdata = ~tgt;
    end
    @(negedge clk);
    mem_rdy = 1'b0;
    chk(!rf_we && !pc_we, "R3 stall", {14'h0, rf_we, pc_we}, 16'h0);
    chk(!mem_req, "R2 pulse", 16'(mem_req), 16'h0);
    for (int i = 0; i < lat; i++) begin
      if (noise) begin
        trap_req = 1'b1; trap_vec = ~v; pc_in = ~pc; ret_req = 1'b1;
        r7_val = 16'($urandom()); mem_rdata = 16'($urandom());
      end
      @(negedge clk);
      trap_req = 1'b0; ret_req = 1'b0;
      chk(!rf_we && !pc_we && !done, "R3 wait", {14'h0, rf_we, pc_we}, 16'h0);
      chk(!mem_req && mem_addr == exp_table_addr(v), "R7 frozen",
          mem_addr, exp_table_addr(v));
    end
    mem_rdy = 1'b1; mem_rdata = tgt;
    if (noise) begin trap_req = 1'b1; trap_vec = ~v; pc_in = ~pc; end
    @(negedge clk);
    mem_rdy = 1'b0; trap_req = 1'b0; mem_rdata = 16'($urandom());
    chk(rf_we && rf_waddr == 3'd7, "R4 link reg", {13'h0, rf_waddr}, 16'h7);
    chk(rf_wdata == pc, "R4 link value", rf_wdata, pc);
    chk(pc_we && pc_next == tgt, "R4 target", pc_next, tgt);
    chk(done && busy, "R8 done", {14'h0, done, busy}, 16'h3);
    @(negedge clk);
    idle_checks("R8 end");
  endtask

  task automatic do_ret(input logic [15:0] r7);
    @(negedge clk);
    ret_req = 1'b1; r7_val = r7;
    @(negedge clk);
    ret_req = 1'b0; r7_val = ~r7;
    chk(pc_we && pc_next == r7, "R5 target", pc_next, r7);
    chk(!rf_we && !mem_req, "R5 no side", {14'h0, rf_we, mem_req}, 16'h0);
    chk(done, "R8 ret done", 16'(done), 16'h1);
    @(negedge clk);
    idle_checks("R8 ret end");
  endtask

  task automatic stray_rdy();
    @(negedge clk);
    mem_rdy = 1'b1; mem_rdata = 16'($urandom());
    @(negedge clk);
    mem_rdy = 1'b0;
    idle_checks("R3 stray");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R8: watchdog actual=%h expected=%h", 16'h1, 16'h0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; trap_req = 1'b0; ret_req = 1'b0; mem_rdy = 1'b0;
    trap_vec = '0; pc_in = '0; r7_val = '0; mem_rdata = '0;
    repeat (3) @(negedge clk);
    idle_checks("R1 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    idle_checks("R1 after reset");

    do_trap(8'h00, 16'h3001, 16'h0400, 0, 1'b0, 1'b0, 1'b0);
    do_trap(8'hFF, 16'hFFFF, 16'h1234, 3, 1'b1, 1'b1, 1'b0);
    do_trap(8'h21, 16'h3010, 16'h0430, 1, 1'b0, 1'b0, 1'b1);
    do_ret(16'h3011);
    stray_rdy();
    do_trap(8'h25, 16'h0000, 16'hFFFF, 6, 1'b1, 1'b0, 1'b0);

    for (int n = 0; n < 60; n++) begin
      if ($urandom_range(3) == 0) do_ret(16'($urandom()));
      else if ($urandom_range(7) == 0) stray_rdy();
      else do_trap(8'($urandom()), 16'($urandom()), 16'($urandom()),
                   int'($urandom_range(5)), 1'($urandom()),
                   1'($urandom()), 1'($urandom()));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule